// File: doc/BRIEF.md
# TLB-Backed Address Translation Unit

This block turns a 14-bit virtual address into a 12-bit physical address for a single requester. Memory is split into 64-byte pages, so the low six address bits are carried straight across and only the page number is translated. Each request first looks in a 16-entry translation buffer, arranged as four sets of four ways. If no valid matching entry is found, the unit walks a single-level page table. It fetches the entry for the page over a memory read port, at an address formed from a base value plus the virtual page number.

Every translation ends in one of three outcomes. A success returns the physical address. A page fault means the table entry is marked not present. A protection fault means the entry lacks the read or write right that the access needs. The unit also reports whether the result came from the buffer. Only successful walks are installed in the buffer. A flush input empties the buffer in one cycle. The unit handles one translation at a time and takes no new request until the current one has answered.

The controller is a five-state machine. IDLE accepts a request (IDLE to LOOKUP). LOOKUP goes to DONE on a buffer hit and to WALK_REQ on a miss. WALK_REQ holds the table read request until it is accepted (WALK_REQ to WALK_WAIT). WALK_WAIT waits for the table entry (WALK_WAIT to DONE). DONE presents the result for one cycle and returns to IDLE.

Top module: `addr_xlate_unit`

## Requirements
- R1: After reset the unit is in IDLE with `req_ready` high, `rsp_valid` low and `pt_req_valid` low, and the buffer holds no valid entry, so the first request to any page walks the table.
- R2: A request's virtual page number is `req_vaddr[13:6]`, its set index is `req_vaddr[7:6]` and its tag is `req_vaddr[13:8]`. A successful result has `rsp_paddr[5:0]` equal to `req_vaddr[5:0]` and `rsp_paddr[11:6]` equal to the entry's physical page number.
- R3: A request whose set holds a valid entry with a matching tag completes without a table read, with `rsp_hit` = 1.
- R4: On a miss, `pt_req_addr` equals `pt_base` plus the virtual page number, and it is held stable with `pt_req_valid` until `pt_req_ready`. The returned entry is laid out as bits [5:0] physical page number, bit 6 read permitted, bit 7 write permitted and bit 8 present.
- R5: A table entry with bit 8 clear gives `rsp_fault` = 1 (page fault) and `rsp_paddr` = 0, whatever its permission bits are.
- R6: A read (`req_write` = 0) needs the read bit and a write needs the write bit. Without that bit the result is `rsp_fault` = 2 (protection fault) with `rsp_paddr` = 0, both on a buffer hit and after a walk. `rsp_fault` = 0 means success.
- R7: A walk that ends in either fault installs nothing, so the next request to that page walks again. A successful walk installs the entry.
- R8: A fill goes into the lowest-numbered invalid way of its set. If the set is full, it replaces the way named by that set's round-robin pointer, which then moves to the next way. Fills in one set leave the other sets unchanged.
- R9: A flush clears every buffer entry in one cycle. If a flush and a fill fall in the same cycle, the flush wins, while the translation being filled still returns its correct result.
- R10: `req_ready` is low from the cycle after acceptance until the unit is back in IDLE, so no request is taken during a lookup or a walk.
- R11: Each accepted request produces exactly one response, with `rsp_valid` high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| pt_base | input | 12 | Page-table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_vaddr | input | 14 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| pt_req_valid | output | 1 | Page-table read request |
| pt_req_ready | input | 1 | Page-table read request accepted |
| pt_req_addr | output | 12 | Page-table entry address |
| pt_rsp_valid | input | 1 | Page-table entry returned |
| pt_rsp_data | input | 9 | Page-table entry |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_paddr | output | 12 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| rsp_hit | output | 1 | Result came from the buffer |

## Verification
A buffer fill and a flush can happen in the same cycle: the fill from a successful walk and an external flush pulse. The bench provokes this by having its page-table responder raise `flush` in the same cycle that it returns the table entry. The case counts as correct when that translation still returns the right physical address, the next request to the same page walks the table again (`rsp_hit` = 0), and a page cached before the flush also misses. The bound checker confirms that every buffer entry is empty one cycle after any flush.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOOKUP    = 3'd1,
        ST_WALK_REQ  = 3'd2,
        ST_WALK_WAIT = 3'd3,
        ST_DONE      = 3'd4
    } state_e;

endpackage

// File: rtl/xlate_perm.sv
module xlate_perm
    import xlate_pkg::*;
(
    input  logic   present,
    input  logic   may_read,
    input  logic   may_write,
    input  logic   is_write,
    output fault_e fault
);

    always_comb begin
        if (!present)
            fault = FLT_PAGE;
        else if (is_write ? !may_write : !may_read)
            fault = FLT_PROT;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [SET_W-1:0]     lk_set,
    input  logic [TAG_W-1:0]     lk_tag,
    output logic                 lk_hit,
    output logic [PPN_W-1:0]     lk_ppn,
    output logic                 lk_rd,
    output logic                 lk_wr,
    input  logic                 fill_en,
    input  logic [SET_W-1:0]     fill_set,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [PPN_W-1:0]     fill_ppn,
    input  logic                 fill_rd,
    input  logic                 fill_wr,
    output logic [SETS*WAYS-1:0] valid_vec
);

    logic [SETS-1:0]  set_hit;
    logic [PPN_W-1:0] set_ppn [SETS];
    logic [SETS-1:0]  set_rd;
    logic [SETS-1:0]  set_wr;

    for (genvar gs = 0; gs < SETS; gs++) begin : g_set
        logic [WAYS-1:0]  vld;
        logic [TAG_W-1:0] tag_q [WAYS];
        logic [PPN_W-1:0] ppn_q [WAYS];
        logic [WAYS-1:0]  rd_q;
        logic [WAYS-1:0]  wr_q;
        logic [WAY_W-1:0] rr_q;
        logic [WAY_W-1:0] victim;
        logic             has_free;
        logic             here;
        logic             hit_s;
        logic [PPN_W-1:0] ppn_s;
        logic             rd_s;
        logic             wr_s;

        assign here = fill_en && (fill_set == SET_W'(gs));

        always_comb begin
            victim   = rr_q;
            has_free = 1'b0;
            for (int i = 0; i < WAYS; i++) begin
                if (!has_free && !vld[i]) begin
                    victim   = WAY_W'(i);
                    has_free = 1'b1;
                end
            end
        end

        always_comb begin
            hit_s = 1'b0;
            ppn_s = '0;
            rd_s  = 1'b0;
            wr_s  = 1'b0;
            for (int i = 0; i < WAYS; i++) begin
                if (!hit_s && vld[i] && (tag_q[i] == lk_tag)) begin
                    hit_s = 1'b1;
                    ppn_s = ppn_q[i];
                    rd_s  = rd_q[i];
                    wr_s  = wr_q[i];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld  <= '0;
                rr_q <= '0;
            end else if (flush) begin
                vld <= '0;
            end else if (here) begin
                vld[victim] <= 1'b1;
                if (!has_free)
                    rr_q <= rr_q + WAY_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (here) begin
                tag_q[victim] <= fill_tag;
                ppn_q[victim] <= fill_ppn;
                rd_q[victim]  <= fill_rd;
                wr_q[victim]  <= fill_wr;
            end
        end

        assign set_hit[gs]                = hit_s;
        assign set_ppn[gs]                = ppn_s;
        assign set_rd[gs]                 = rd_s;
        assign set_wr[gs]                 = wr_s;
        assign valid_vec[gs*WAYS +: WAYS] = vld;
    end

    assign lk_hit = set_hit[lk_set];
    assign lk_ppn = set_ppn[lk_set];
    assign lk_rd  = set_rd[lk_set];
    assign lk_wr  = set_wr[lk_set];

endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
    import xlate_pkg::*;
#(
    parameter int VA_W       = 14,
    parameter int PA_W       = 12,
    parameter int PAGE_BYTES = 64,
    parameter int TLB_SETS   = 4,
    parameter int TLB_WAYS   = 4,
    parameter int PTA_W      = 12,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int VPN_W     = VA_W - OFF_W,
    localparam int PPN_W     = PA_W - OFF_W,
    localparam int SET_W     = $clog2(TLB_SETS),
    localparam int TAG_W     = VPN_W - SET_W,
    localparam int PTE_W     = PPN_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PTA_W-1:0] pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             pt_req_valid,
    input  logic             pt_req_ready,
    output logic [PTA_W-1:0] pt_req_addr,
    input  logic             pt_rsp_valid,
    input  logic [PTE_W-1:0] pt_rsp_data,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic             rsp_hit
);

    localparam int NENT = TLB_SETS * TLB_WAYS;

    state_e           st_q, st_d;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic             wr_q;
    logic [PA_W-1:0]  pa_q;
    fault_e           flt_q;
    logic             hit_q;

    logic             tlb_hit, tlb_rd, tlb_wr;
    logic [PPN_W-1:0] tlb_ppn;
    logic [NENT-1:0]  tlb_valid_vec;

    logic             pte_present, pte_rd, pte_wr;
    logic [PPN_W-1:0] pte_ppn;

    logic             c_present, c_rd, c_wr;
    logic [PPN_W-1:0] c_ppn;
    fault_e           chk_fault;

    logic             accept, walk_done, lookup_done, fill_en;

    assign pte_ppn     = pt_rsp_data[PPN_W-1:0];
    assign pte_rd      = pt_rsp_data[PPN_W];
    assign pte_wr      = pt_rsp_data[PPN_W+1];
    assign pte_present = pt_rsp_data[PPN_W+2];

    assign accept      = (st_q == ST_IDLE) && req_valid;
    assign lookup_done = (st_q == ST_LOOKUP) && tlb_hit;
    assign walk_done   = (st_q == ST_WALK_WAIT) && pt_rsp_valid;
    assign fill_en     = walk_done && (chk_fault == FLT_NONE);

    xlate_tlb #(
        .SETS  (TLB_SETS),
        .WAYS  (TLB_WAYS),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W)
    ) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_set    (vpn_q[SET_W-1:0]),
        .lk_tag    (vpn_q[VPN_W-1:SET_W]),
        .lk_hit    (tlb_hit),
        .lk_ppn    (tlb_ppn),
        .lk_rd     (tlb_rd),
        .lk_wr     (tlb_wr),
        .fill_en   (fill_en),
        .fill_set  (vpn_q[SET_W-1:0]),
        .fill_tag  (vpn_q[VPN_W-1:SET_W]),
        .fill_ppn  (pte_ppn),
        .fill_rd   (pte_rd),
        .fill_wr   (pte_wr),
        .valid_vec (tlb_valid_vec)
    );

    // Permission source: cached entry during lookup, fetched entry during a walk
    always_comb begin
        if (st_q == ST_LOOKUP) begin
            c_present = 1'b1;
            c_rd      = tlb_rd;
            c_wr      = tlb_wr;
            c_ppn     = tlb_ppn;
        end else begin
            c_present = pte_present;
            c_rd      = pte_rd;
            c_wr      = pte_wr;
            c_ppn     = pte_ppn;
        end
    end

    xlate_perm u_perm (
        .present   (c_present),
        .may_read  (c_rd),
        .may_write (c_wr),
        .is_write  (wr_q),
        .fault     (chk_fault)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (req_valid)    st_d = ST_LOOKUP;
            ST_LOOKUP:    st_d = tlb_hit ? ST_DONE : ST_WALK_REQ;
            ST_WALK_REQ:  if (pt_req_ready) st_d = ST_WALK_WAIT;
            ST_WALK_WAIT: if (pt_rsp_valid) st_d = ST_DONE;
            ST_DONE:      st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready    = (st_q == ST_IDLE);
        pt_req_valid = (st_q == ST_WALK_REQ);
        rsp_valid    = (st_q == ST_DONE);
        pt_req_addr  = pt_base + PTA_W'(vpn_q);
        rsp_paddr    = pa_q;
        rsp_fault    = flt_q;
        rsp_hit      = hit_q;
    end

    // Request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q <= '0;
            off_q <= '0;
            wr_q  <= 1'b0;
            pa_q  <= '0;
            flt_q <= FLT_NONE;
            hit_q <= 1'b0;
        end else begin
            if (accept) begin
                vpn_q <= req_vaddr[VA_W-1:OFF_W];
                off_q <= req_vaddr[OFF_W-1:0];
                wr_q  <= req_write;
            end
            if (lookup_done || walk_done) begin
                flt_q <= chk_fault;
                hit_q <= lookup_done;
                pa_q  <= (chk_fault == FLT_NONE) ? {c_ppn, off_q} : '0;
            end
        end
    end

endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
    parameter int VA_W  = 14,
    parameter int PA_W  = 12,
    parameter int OFF_W = 6,
    parameter int PTA_W = 12,
    parameter int NENT  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             pt_req_valid,
    input logic             pt_req_ready,
    input logic [PTA_W-1:0] pt_req_addr,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_fault,
    input logic             rsp_hit,
    input logic [NENT-1:0]  tlb_valid
);

    logic [OFF_W-1:0] exp_off;
    logic             walked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_off <= '0;
            walked  <= 1'b0;
        end else if (req_valid && req_ready) begin
            exp_off <= req_vaddr[OFF_W-1:0];
            walked  <= 1'b0;
        end else if (pt_req_valid && pt_req_ready) begin
            walked <= 1'b1;
        end
    end

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault == 2'd0) |-> rsp_paddr[OFF_W-1:0] == exp_off); // R2

    AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> !walked); // R3

    AST_PTREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req_valid && !pt_req_ready |=> pt_req_valid && $stable(pt_req_addr)); // R4

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != 2'd0) |-> rsp_paddr == '0); // R5

    AST_HIT_NOT_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> rsp_fault != 2'd1); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> tlb_valid == '0); // R9

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req_valid |-> !req_ready); // R10

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11

endmodule

bind addr_xlate_unit xlate_checker #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .OFF_W (OFF_W),
    .PTA_W (PTA_W),
    .NENT  (NENT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .pt_req_valid (pt_req_valid),
    .pt_req_ready (pt_req_ready),
    .pt_req_addr  (pt_req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .rsp_hit      (rsp_hit),
    .tlb_valid    (tlb_valid_vec)
);

// File: tb/sim_addr_xlate_unit.sv
`timescale 1ns/1ps
module sim_addr_xlate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [11:0] pt_base = 12'h100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        pt_req_valid;
    logic        pt_req_ready = 1'b0;
    logic [11:0] pt_req_addr;
    logic        pt_rsp_valid = 1'b0;
    logic [8:0]  pt_rsp_data = '0;
    logic        rsp_valid;
    logic [11:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        rsp_hit;

    always #10 clk = ~clk;

    addr_xlate_unit u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .pt_req_valid(pt_req_valid),
        .pt_req_ready(pt_req_ready), .pt_req_addr(pt_req_addr),
        .pt_rsp_valid(pt_rsp_valid), .pt_rsp_data(pt_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_hit(rsp_hit)
    );

    typedef struct packed {
        logic [11:0] pa;
        logic [1:0]  flt;
        logic        hit;
    } exp_t;

    exp_t  exp_q[$];
    string name_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    flush_on_rsp = 1'b0;
    logic [7:0] last_vpn = '0;
    int    walk_cnt = 0;

    // Table entry: [8] present, [7] write, [6] read, [5:0] page number
    function automatic logic [8:0] pte_of(input logic [7:0] v);
        logic [5:0] p;
        p = (v[5:0] ^ 6'h15) + {4'b0, v[7:6]};
        case (v[2:0])
            3'd5:       return {3'b011, p};
            3'd4, 3'd7: return {3'b101, p};
            3'd6:       return {3'b110, p};
            default:    return {3'b111, p};
        endcase
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic xlate(input logic [7:0] vpn, input logic [5:0] off,
                         input bit wr, input bit exp_hit, input string rq);
        logic [8:0] e;
        exp_t       x;
        e = pte_of(vpn);
        if (!e[8])
            x.flt = 2'd1;
        else if (wr ? !e[7] : !e[6])
            x.flt = 2'd2;
        else
            x.flt = 2'd0;
        x.pa  = (x.flt == 2'd0) ? {e[5:0], off} : 12'h000;
        x.hit = exp_hit;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(x);
        name_q.push_back(rq);
        last_vpn  = vpn;
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Monitor: compare results against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R11", "unexpected response", 32'd1, 32'd0);
                end else begin
                    exp_t  x;
                    string rq;
                    x  = exp_q.pop_front();
                    rq = name_q.pop_front();
                    chk(rq, "paddr", {20'd0, rsp_paddr}, {20'd0, x.pa});
                    chk(rq, "fault", {30'd0, rsp_fault}, {30'd0, x.flt});
                    chk(rq, "hit",   {31'd0, rsp_hit},   {31'd0, x.hit});
                end
            end
        end
    end

    // Page-table memory model with varying latency
    initial begin
        forever begin
            @(negedge clk);
            if (pt_req_valid) begin
                logic [11:0] a;
                walk_cnt++;
                repeat (walk_cnt % 3) @(negedge clk);
                a = pt_req_addr;
                chk("R4", "table address", {20'd0, a}, {20'd0, pt_base + {4'd0, last_vpn}});
                chk("R10", "ready during walk", {31'd0, req_ready}, 32'd0);
                pt_req_ready = 1'b1;
                @(negedge clk);
                pt_req_ready = 1'b0;
                repeat (walk_cnt % 4) @(negedge clk);
                pt_rsp_valid = 1'b1;
                pt_rsp_data  = pte_of(a[7:0] - pt_base[7:0]);
                if (flush_on_rsp) flush = 1'b1;
                @(negedge clk);
                pt_rsp_valid = 1'b0;
                if (flush_on_rsp) begin
                    flush = 1'b0;
                    flush_on_rsp = 1'b0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1", "pt_req_valid", {31'd0, pt_req_valid}, 32'd0);

        // R1 empty buffer, R2 address forming, R3 hits
        xlate(8'h08, 6'h3F, 1'b0, 1'b0, "R1");
        xlate(8'h08, 6'h00, 1'b0, 1'b1, "R3");
        xlate(8'h08, 6'h15, 1'b1, 1'b1, "R2");

        // R6 protection, R7 no install on fault
        xlate(8'h0C, 6'h07, 1'b1, 1'b0, "R6");
        xlate(8'h0C, 6'h07, 1'b1, 1'b0, "R7");
        xlate(8'h0C, 6'h01, 1'b0, 1'b0, "R7");
        xlate(8'h0C, 6'h02, 1'b1, 1'b1, "R6");

        // R5 page fault
        xlate(8'h0D, 6'h10, 1'b0, 1'b0, "R5");
        xlate(8'h0D, 6'h11, 1'b1, 1'b0, "R7");

        xlate(8'h0E, 6'h20, 1'b0, 1'b0, "R6");
        xlate(8'h0E, 6'h21, 1'b1, 1'b0, "R7");
        xlate(8'h0E, 6'h22, 1'b0, 1'b1, "R6");

        // R9 flush
        do_flush();
        xlate(8'h08, 6'h05, 1'b0, 1'b0, "R9");

        // R8 replacement in set 0
        do_flush();
        xlate(8'h10, 6'h01, 1'b0, 1'b0, "R8");
        xlate(8'h20, 6'h02, 1'b0, 1'b0, "R8");
        xlate(8'h30, 6'h03, 1'b0, 1'b0, "R8");
        xlate(8'h40, 6'h04, 1'b0, 1'b0, "R8");
        xlate(8'h10, 6'h05, 1'b0, 1'b1, "R8");
        xlate(8'h50, 6'h06, 1'b0, 1'b0, "R8");
        xlate(8'h20, 6'h07, 1'b0, 1'b1, "R8");
        xlate(8'h10, 6'h08, 1'b0, 1'b0, "R8");
        xlate(8'h20, 6'h09, 1'b0, 1'b0, "R8");
        xlate(8'h40, 6'h0A, 1'b0, 1'b1, "R8");
        xlate(8'h50, 6'h0B, 1'b0, 1'b1, "R8");
        xlate(8'h10, 6'h0C, 1'b1, 1'b1, "R8");
        xlate(8'h30, 6'h0D, 1'b0, 1'b0, "R8");
        xlate(8'h40, 6'h0E, 1'b0, 1'b0, "R8");
        xlate(8'h11, 6'h0F, 1'b0, 1'b0, "R8");
        xlate(8'h11, 6'h30, 1'b0, 1'b1, "R8");
        xlate(8'h10, 6'h31, 1'b0, 1'b1, "R8");

        // R9 flush in the same cycle as a fill
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        flush_on_rsp = 1'b1;
        xlate(8'h18, 6'h2A, 1'b0, 1'b0, "R9");
        xlate(8'h18, 6'h2B, 1'b0, 1'b0, "R9");
        xlate(8'h10, 6'h2C, 1'b0, 1'b0, "R9");
        xlate(8'h18, 6'h2D, 1'b1, 1'b1, "R3");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R11", "pending responses", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule